// File: doc/BRIEF.md
# Toggle-Write Memory Cycle Sequencer

This block is the control core of a word-organised non-volatile memory whose storage cells cannot be set to a chosen value. A write pulse can only invert a cell. The sequencer watches an asynchronous chip-select line from the system clock domain and rejects short glitches on it. On every qualified rising edge it captures an address and a write-enable, then runs one memory cycle.

A read cycle fetches the stored word, which is the data plus its Hamming check bits. It corrects any single-bit upset and presents the corrected data on the output bus. The bus is driven only while output enable is high. A write cycle first reads the stored word. It then encodes the new data and forms the exclusive-or of the stored and the new codewords. It pulses only the differing cells, in a single array-update cycle. A separate asynchronous write-go input can hold the update off for as long as the host needs. Per-region active-low inhibit lines block writes to their half of the address space.

Top module: `toggle_mem_seq`

## Requirements
- R1: After reset the data-output enable is low and no cycle is in progress.
- R2: After a two-flop synchroniser, chip-select must be seen high for FILT_CYC consecutive clock samples (default 3) to start a cycle. A shorter high pulse starts nothing. A longer one starts exactly one cycle.
- R3: Address and write-enable are taken at the qualifying sample. Later changes during the same cycle have no effect.
- R4: A read (write-enable captured low) drives the corrected word on dq_o. dq_oe_o is high only while output enable is high, a completed read result is held and chip-select stays high. Output enable is not captured, so changing it alone switches dq_oe_o.
- R5: A permitted write leaves the array holding the Hamming codeword of the written data. A later read of that address returns the data.
- R6: A write reads the stored word first and inverts only the cells whose value differs from the new codeword. Successive writes of different data to one address read back as the latest data.
- R7: The stored word is {check bits, data}, with the data in the low DATA_W bits. Check bit k is the parity of the codeword positions 1..N whose index has bit k set, and the data bits fill the non-power-of-two positions in ascending order. Any single flipped bit in a stored word, whether a data bit or a check bit, is corrected on read.
- R8: When write-go is low at the write stage, the update waits and completes once write-go (synchronised) goes high. Write data is sampled in the update cycle.
- R9: wi_n_i[0] low blocks writes to addresses with MSB 0, and wi_n_i[1] low blocks writes to addresses with MSB 1. A blocked write ends with the array unchanged.
- R10: A qualified chip-select edge that arrives while a cycle, including a deferred write, is in progress is ignored.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| cs_i | input | 1 | Chip select, asynchronous, rising edge starts a cycle |
| addr_i | input | ADDR_W | Word address |
| we_i | input | 1 | Write enable, captured with the address |
| wgo_i | input | 1 | Asynchronous write-go, write proceeds while high |
| wi_n_i | input | REGIONS | Active-low write inhibit, one line per address region |
| oe_i | input | 1 | Output enable, not captured |
| dq_i | input | DATA_W | Write data |
| dq_o | output | DATA_W | Corrected read data |
| dq_oe_o | output | 1 | Drive enable for dq_o, low means high-impedance |

## Verification
The assertions assume that address, write-enable and write data stay stable while chip-select is high and until the update cycle ends. They also assume the inhibit lines are steady around the update cycle, and that the stored array is changed only by the sequencer, except where a single-bit upset is injected on the read path. The stimulus sets every bus value before raising chip-select and holds it through the whole pulse. It changes inhibit lines and write-go only while the block is idle or waiting. It injects upsets by overriding the array read word for the length of one read.

// File: rtl/tmem_pkg.sv
`timescale 1ns/1ps
package tmem_pkg;
   // Smallest number of Hamming check bits that covers dw data bits.
   function automatic int hamm_chk_w(input int dw);
      int r;
      r = 1;
      while ((1 << r) < dw + r + 1) r++;
      return r;
   endfunction

   typedef enum logic [1:0] {ST_IDLE, ST_FETCH, ST_WAIT} seq_st_e;
endpackage

// File: rtl/tmem_cs_filter.sv
`timescale 1ns/1ps
module tmem_cs_filter #(
   parameter int FILT_CYC = 3
) (
   input  logic clk,
   input  logic rst_n,
   input  logic cs_i,
   output logic cs_lvl_o,
   output logic fire_o
);
   logic s1, s2;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         s1 <= 1'b0;
         s2 <= 1'b0;
      end else begin
         s1 <= cs_i;
         s2 <= s1;
      end
   end

   assign cs_lvl_o = s2;

   generate
      if (FILT_CYC <= 1) begin : g_edge
         logic s2_d;
         always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n) s2_d <= 1'b0;
            else        s2_d <= s2;
         end
         assign fire_o = s2 & ~s2_d;
      end else begin : g_count
         localparam int CW = $clog2(FILT_CYC + 1);
         logic [CW-1:0] cnt;
         always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n)                   cnt <= '0;
            else if (!s2)                 cnt <= '0;
            else if (cnt != CW'(FILT_CYC)) cnt <= cnt + 1'b1;
         end
         assign fire_o = s2 && (cnt == CW'(FILT_CYC - 1));

         // R2
         one_fire_chk: assert property (@(posedge clk) disable iff (!rst_n)
            fire_o |=> !fire_o);
      end
   endgenerate
endmodule

// File: rtl/tmem_ecc.sv
`timescale 1ns/1ps
module tmem_ecc #(
   parameter int DATA_W = 16,
   parameter int CHK_W  = 5
) (
   input  logic [DATA_W-1:0]       enc_d_i,
   output logic [CHK_W-1:0]        enc_chk_o,
   input  logic [CHK_W+DATA_W-1:0] dec_word_i,
   output logic [DATA_W-1:0]       dec_d_o
);
   localparam int N = DATA_W + CHK_W;

   // Codeword position of data bit i (non-power-of-two slots, ascending).
   function automatic int dpos(input int i);
      int n;
      dpos = 0;
      n = 0;
      for (int p = 1; p <= N; p++) begin
         if ((p & (p - 1)) != 0) begin
            if (n == i) dpos = p;
            n++;
         end
      end
   endfunction

   always_comb begin
      enc_chk_o = '0;
      for (int i = 0; i < DATA_W; i++)
         for (int k = 0; k < CHK_W; k++)
            if (((dpos(i) >> k) & 1) != 0) enc_chk_o[k] = enc_chk_o[k] ^ enc_d_i[i];
   end

   logic [CHK_W-1:0] syn;
   always_comb begin
      syn = dec_word_i[N-1:DATA_W];
      for (int i = 0; i < DATA_W; i++)
         for (int k = 0; k < CHK_W; k++)
            if (((dpos(i) >> k) & 1) != 0) syn[k] = syn[k] ^ dec_word_i[i];
      for (int i = 0; i < DATA_W; i++)
         dec_d_o[i] = dec_word_i[i] ^ (int'(syn) == dpos(i));
   end
endmodule

// File: rtl/tmem_array.sv
`timescale 1ns/1ps
module tmem_array #(
   parameter int ADDR_W = 8,
   parameter int WORD_W = 21
) (
   input  logic              clk,
   input  logic [ADDR_W-1:0] addr_i,
   output logic [WORD_W-1:0] rd_word_o,
   input  logic              tgl_en_i,
   input  logic [WORD_W-1:0] tgl_mask_i
);
   localparam int DEPTH = 1 << ADDR_W;

   generate
      if (ADDR_W > 12) begin : g_too_big
         $error("tmem_array: ADDR_W above 12 exceeds the model size limit");
      end
   endgenerate

   logic [WORD_W-1:0] mem [DEPTH];

   // Cells only invert: the update is a per-bit toggle.
   always_ff @(posedge clk) begin
      if (tgl_en_i) mem[addr_i] <= mem[addr_i] ^ tgl_mask_i;
   end

   assign rd_word_o = mem[addr_i];
endmodule

// File: rtl/tmem_inhibit.sv
`timescale 1ns/1ps
module tmem_inhibit #(
   parameter int ADDR_W  = 8,
   parameter int REGIONS = 2
) (
   input  logic [ADDR_W-1:0]  addr_i,
   input  logic [REGIONS-1:0] wi_n_i,
   output logic               blocked_o
);
   generate
      if (REGIONS == 1) begin : g_single
         assign blocked_o = !wi_n_i[0];
      end else begin : g_multi
         localparam int REG_W = $clog2(REGIONS);
         logic [REG_W-1:0] region;
         assign region    = addr_i[ADDR_W-1 -: REG_W];
         assign blocked_o = !wi_n_i[region];
      end
   endgenerate
endmodule

// File: rtl/toggle_mem_seq.sv
`timescale 1ns/1ps
module toggle_mem_seq #(
   parameter int ADDR_W   = 8,
   parameter int DATA_W   = 16,
   parameter int FILT_CYC = 3,
   parameter int REGIONS  = 2
) (
   input  logic               clk,
   input  logic               rst_n,
   input  logic               cs_i,
   input  logic [ADDR_W-1:0]  addr_i,
   input  logic               we_i,
   input  logic               wgo_i,
   input  logic [REGIONS-1:0] wi_n_i,
   input  logic               oe_i,
   input  logic [DATA_W-1:0]  dq_i,
   output logic [DATA_W-1:0]  dq_o,
   output logic               dq_oe_o
);
   import tmem_pkg::*;

   localparam int CHK_W  = hamm_chk_w(DATA_W);
   localparam int WORD_W = DATA_W + CHK_W;

   generate
      if (DATA_W < 2) begin : g_bad_data
         $error("toggle_mem_seq: DATA_W must be at least 2");
      end
      if ((REGIONS < 1) || ((REGIONS & (REGIONS - 1)) != 0)) begin : g_bad_reg
         $error("toggle_mem_seq: REGIONS must be a power of two");
      end
      if ((1 << ADDR_W) < REGIONS) begin : g_bad_addr
         $error("toggle_mem_seq: ADDR_W too small for REGIONS");
      end
   endgenerate

   logic cs_lvl, fire;
   tmem_cs_filter #(.FILT_CYC(FILT_CYC)) u_filt (
      .clk(clk), .rst_n(rst_n), .cs_i(cs_i), .cs_lvl_o(cs_lvl), .fire_o(fire));

   logic g1, wgo_s;
   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         g1    <= 1'b0;
         wgo_s <= 1'b0;
      end else begin
         g1    <= wgo_i;
         wgo_s <= g1;
      end
   end

   seq_st_e           st;
   logic [ADDR_W-1:0] addr_q;
   logic              we_q;
   logic [WORD_W-1:0] word_q;
   logic              rd_valid;
   logic [WORD_W-1:0] arr_rd;
   logic [CHK_W-1:0]  new_chk;
   logic [WORD_W-1:0] new_cw;
   logic              blocked;
   logic              tgl_en;

   tmem_ecc #(.DATA_W(DATA_W), .CHK_W(CHK_W)) u_ecc (
      .enc_d_i(dq_i), .enc_chk_o(new_chk), .dec_word_i(word_q), .dec_d_o(dq_o));

   tmem_inhibit #(.ADDR_W(ADDR_W), .REGIONS(REGIONS)) u_inh (
      .addr_i(addr_q), .wi_n_i(wi_n_i), .blocked_o(blocked));

   assign new_cw = {new_chk, dq_i};
   assign tgl_en = (st == ST_WAIT) && wgo_s && !blocked;

   tmem_array #(.ADDR_W(ADDR_W), .WORD_W(WORD_W)) u_arr (
      .clk(clk), .addr_i(addr_q), .rd_word_o(arr_rd),
      .tgl_en_i(tgl_en), .tgl_mask_i(word_q ^ new_cw));

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         st       <= ST_IDLE;
         addr_q   <= '0;
         we_q     <= 1'b0;
         word_q   <= '0;
         rd_valid <= 1'b0;
      end else begin
         unique case (st)
            ST_IDLE: if (fire) begin
               addr_q   <= addr_i;
               we_q     <= we_i;
               rd_valid <= 1'b0;
               st       <= ST_FETCH;
            end
            ST_FETCH: begin
               word_q   <= arr_rd;
               rd_valid <= !we_q;
               st       <= we_q ? ST_WAIT : ST_IDLE;
            end
            ST_WAIT: if (wgo_s) st <= ST_IDLE;
            default: st <= ST_IDLE;
         endcase
      end
   end

   assign dq_oe_o = rd_valid && oe_i && cs_lvl;

   // R5
   wr_store_chk: assert property (@(posedge clk) disable iff (!rst_n)
      tgl_en |=> (arr_rd == $past(new_cw)));

   // R8
   wait_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (st == ST_WAIT && !wgo_s) |=> (st == ST_WAIT));

   // R9
   inhibit_keep_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (st == ST_WAIT && wgo_s && blocked) |=> (arr_rd == $past(arr_rd)));

   // R10
   busy_ignore_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (st != ST_IDLE && fire) |=> (addr_q == $past(addr_q)));
endmodule

// File: tb/tb_toggle_mem_seq.sv
`timescale 1ns/1ps
module tb_toggle_mem_seq;
   logic        clk = 1'b0;
   logic        rst_n = 1'b0;
   logic        cs_i = 1'b0;
   logic [7:0]  addr_i = '0;
   logic        we_i = 1'b0;
   logic        wgo_i = 1'b1;
   logic [1:0]  wi_n_i = 2'b11;
   logic        oe_i = 1'b0;
   logic [15:0] dq_i = '0;
   logic [15:0] dq_o;
   logic        dq_oe_o;

   int checks = 0;
   int errors = 0;
   logic [15:0] model [16];
   logic [7:0]  pa [16];
   logic [20:0] inj;

   toggle_mem_seq dut (
      .clk(clk), .rst_n(rst_n), .cs_i(cs_i), .addr_i(addr_i), .we_i(we_i),
      .wgo_i(wgo_i), .wi_n_i(wi_n_i), .oe_i(oe_i), .dq_i(dq_i),
      .dq_o(dq_o), .dq_oe_o(dq_oe_o));

   always #2.5 clk = ~clk;

   function automatic logic [20:0] benc(input logic [15:0] d);
      logic [4:0] c;
      int j;
      c = '0;
      j = 0;
      for (int p = 1; p <= 21; p++) begin
         if ((p & (p - 1)) != 0) begin
            for (int k = 0; k < 5; k++) if (p[k]) c[k] = c[k] ^ d[j];
            j++;
         end
      end
      return {c, d};
   endfunction

   task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
      checks++;
      if (act !== exp) begin
         errors++;
         $display("FAIL %s actual=%h expected=%h", req, act, exp);
      end
   endtask

   task automatic wr(input logic [7:0] a, input logic [15:0] d);
      @(negedge clk);
      addr_i = a; we_i = 1'b1; dq_i = d; cs_i = 1'b1;
      repeat (8) @(negedge clk);
      cs_i = 1'b0;
      repeat (4) @(negedge clk);
   endtask

   task automatic rd(input logic [7:0] a, input logic oe,
                     output logic [15:0] d, output logic en);
      @(negedge clk);
      addr_i = a; we_i = 1'b0; oe_i = oe; cs_i = 1'b1;
      repeat (8) @(negedge clk);
      d = dq_o; en = dq_oe_o;
      cs_i = 1'b0;
      repeat (3) @(negedge clk);
   endtask

   initial begin : main
      logic [15:0] d;
      logic en;
      repeat (3) @(negedge clk);
      // R1 reset state
      chk("R1 oe after reset", {31'd0, dq_oe_o}, 32'd0);
      rst_n = 1'b1;
      repeat (2) @(negedge clk);
      chk("R1 idle after reset", {31'd0, dq_oe_o}, 32'd0);

      // preset 16 locations across both halves
      for (int i = 0; i < 16; i++) begin
         pa[i] = 8'(i * 16 + i);
         model[i] = 16'(i * 16'h1357 + 16'h0a0a);
         wr(pa[i], model[i]);
      end
      // R5 read back
      for (int i = 0; i < 16; i++) begin
         rd(pa[i], 1'b1, d, en);
         chk("R5 read data", {16'd0, d}, {16'd0, model[i]});
         chk("R4 drive enable", {31'd0, en}, 32'd1);
      end

      // R6 rewrite with different data twice
      wr(pa[2], 16'hffff); wr(pa[2], 16'h8001); model[2] = 16'h8001;
      rd(pa[2], 1'b1, d, en);
      chk("R6 toggle rewrite", {16'd0, d}, 32'h8001);

      // R4 output enable low / not captured / deselect
      rd(pa[3], 1'b0, d, en);
      chk("R4 oe low hiz", {31'd0, en}, 32'd0);
      @(negedge clk);
      addr_i = pa[3]; we_i = 1'b0; oe_i = 1'b0; cs_i = 1'b1;
      repeat (8) @(negedge clk);
      oe_i = 1'b1;
      @(negedge clk);
      chk("R4 oe raised late", {15'd0, dq_oe_o, dq_o}, {15'd0, 1'b1, model[3]});
      cs_i = 1'b0;
      repeat (3) @(negedge clk);
      chk("R4 deselect hiz", {31'd0, dq_oe_o}, 32'd0);

      // R2 glitch ignored: 2-cycle pulse requesting a write
      @(negedge clk);
      addr_i = pa[4]; we_i = 1'b1; dq_i = 16'hdead; cs_i = 1'b1;
      repeat (2) @(negedge clk);
      cs_i = 1'b0;
      repeat (6) @(negedge clk);
      rd(pa[4], 1'b1, d, en);
      chk("R2 glitch no write", {16'd0, d}, {16'd0, model[4]});

      // R3 address/we change after qualification
      @(negedge clk);
      addr_i = pa[5]; we_i = 1'b0; oe_i = 1'b1; cs_i = 1'b1;
      repeat (6) @(negedge clk);
      addr_i = pa[6]; we_i = 1'b1; dq_i = 16'h0bad;
      repeat (2) @(negedge clk);
      chk("R3 captured address", {15'd0, dq_oe_o, dq_o}, {15'd0, 1'b1, model[5]});
      cs_i = 1'b0;
      repeat (4) @(negedge clk);
      rd(pa[6], 1'b1, d, en);
      chk("R3 captured we", {16'd0, d}, {16'd0, model[6]});

      // R7 single-bit upsets on the read path
      for (int b = 0; b < 21; b += 4) begin
         inj = benc(model[7]) ^ (21'd1 << b);
         force dut.u_arr.rd_word_o = inj;
         rd(pa[7], 1'b1, d, en);
         release dut.u_arr.rd_word_o;
         chk("R7 corrected", {16'd0, d}, {16'd0, model[7]});
      end

      // R8 deferred write and R10 edge ignored while pending
      @(negedge clk);
      wgo_i = 1'b0;
      wr(pa[8], 16'h4242);
      repeat (10) @(negedge clk);
      rd(pa[9], 1'b1, d, en);
      chk("R10 read ignored while pending", {31'd0, en}, 32'd0);
      @(negedge clk);
      addr_i = pa[8]; we_i = 1'b1; dq_i = 16'h4343;
      wgo_i = 1'b1;
      repeat (6) @(negedge clk);
      model[8] = 16'h4343;
      rd(pa[8], 1'b1, d, en);
      chk("R8 deferred write data", {16'd0, d}, 32'h4343);
      rd(pa[9], 1'b1, d, en);
      chk("R10 other address intact", {16'd0, d}, {16'd0, model[9]});

      // R9 inhibits
      wi_n_i = 2'b10;
      wr(pa[1], 16'h1111);
      wr(pa[12], 16'hcccc); model[12] = 16'hcccc;
      rd(pa[1], 1'b1, d, en);
      chk("R9 lower blocked", {16'd0, d}, {16'd0, model[1]});
      rd(pa[12], 1'b1, d, en);
      chk("R9 upper allowed", {16'd0, d}, 32'hcccc);
      wi_n_i = 2'b01;
      wr(pa[13], 16'h3333);
      rd(pa[13], 1'b1, d, en);
      chk("R9 upper blocked", {16'd0, d}, {16'd0, model[13]});
      wi_n_i = 2'b11;

      // random mix
      void'($urandom(32'd77));
      for (int n = 0; n < 120; n++) begin
         int idx;
         logic [15:0] nd;
         logic [1:0]  wn;
         idx = int'($urandom % 16);
         if ($urandom % 2 == 0) begin
            nd = 16'($urandom);
            wn = 2'($urandom);
            wi_n_i = wn;
            if ($urandom % 4 == 0) begin
               wgo_i = 1'b0;
               wr(pa[idx], nd);
               repeat (int'($urandom % 12)) @(negedge clk);
               addr_i = pa[idx]; we_i = 1'b1; dq_i = nd;
               wgo_i = 1'b1;
               repeat (6) @(negedge clk);
            end else begin
               wr(pa[idx], nd);
            end
            if (wn[pa[idx][7]]) model[idx] = nd;
            wi_n_i = 2'b11;
         end else begin
            logic oe;
            oe = 1'($urandom);
            rd(pa[idx], oe, d, en);
            chk("R4 random enable", {31'd0, en}, {31'd0, oe});
            if (oe) chk("R9 R5 random data", {16'd0, d}, {16'd0, model[idx]});
         end
      end

      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
   end

   initial begin : watchdog
      repeat (150000) @(posedge clk);
      checks++;
      errors++;
      $display("FAIL watchdog actual=running expected=done");
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
   end
endmodule